// File: doc/BRIEF.md
# Port-Mapped Accumulator Arithmetic Unit

This block is the arithmetic unit of a processor that has no opcodes: every instruction is a move from one bus port to another. Here, a move becomes an operation. The unit holds one 32-bit accumulator and answers a short, contiguous window of port addresses. Each address has its own read effect and its own write effect. A read can return the accumulator plain, bit-inverted or negated. A write can load it, add into it, subtract from it, shift it, or replace a single byte of it.

The sequencer presents a port address together with a read strobe, a write strobe, or both. The unit ignores any address outside its window. Read data is combinational from the current accumulator value, and it is zero whenever the unit is not selected, so it can be OR-ed onto a shared read bus. A write takes effect at the next rising clock edge.

The window starts at the parameter `BASE_ADDR`, which defaults to 0x28. The rest of the window follows in a fixed order.

Top module: `acc_port_alu`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator to zero, so a read of offset 0 (address 0x28) returns 0 after reset.
- R2: A write to offset 0 (0x28) loads `wr_data` into the accumulator. A read of offset 0 returns the accumulator.
- R3: A read of offset 1 (0x29) returns the bitwise inverse of the accumulator. A write to offset 1 adds `wr_data` into the accumulator modulo 2^32.
- R4: A read of offset 2 (0x2A) returns the two's-complement negation of the accumulator. A write to offset 2 subtracts `wr_data` from the accumulator modulo 2^32.
- R5: A write to offset 3 (0x2B) shifts the accumulator left by `wr_data[4:0]` and fills with zeros. Higher bits of `wr_data` are ignored.
- R6: A write to offset 4 (0x2C) shifts the accumulator right logically by `wr_data[4:0]` and fills with zeros.
- R7: A write to offset 5+k (0x2D to 0x30, for k = 0 to 3) replaces accumulator byte k (bits 8k+7:8k) with `wr_data[7:0]` and leaves the other bytes unchanged.
- R8: A read of offset 5+k returns accumulator byte k, zero-extended to 32 bits.
- R9: Reads never change the accumulator. Reads of offsets 3 and 4 return zero.
- R10: Writes to addresses outside the window (below 0x28 or above 0x30) leave the accumulator unchanged. Reads of such addresses return zero.
- R11: `rd_data` follows the current accumulator in the same cycle that `rd_en` is high, and it is zero while `rd_en` is low. When a read and a write happen in the same cycle, the read returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 8 | Port address of the current move |
| rd_en | input | 1 | Read strobe for `port_addr` |
| rd_data | output | 32 | Read result, zero when not selected |
| wr_en | input | 1 | Write strobe for `port_addr` |
| wr_data | input | 32 | Value written to `port_addr` |

## Verification
The bound checker watches every cycle. It checks that each write port produces its arithmetic result on the next edge and that the plain, inverted, negated, low-lane and write-only reads return the right values. It also checks that out-of-window writes leave the accumulator untouched and that the read bus is quiet while no read is strobed. The directed scenarios cover what single-cycle properties cannot show well. These are the modular wrap of add and subtract, shifts by 0 and 31 with high amount bits ignored, byte replacement in every lane, and the effect of a sequence of byte writes. They also cover a read and a write to the same port in one cycle.

// File: rtl/acc_port_alu_pkg.sv
package acc_port_alu_pkg;

    // Fixed order of the port window, relative to its base address.
    localparam int OFF_PLAIN = 0;
    localparam int OFF_ADDSUM = 1;
    localparam int OFF_SUBNEG = 2;
    localparam int OFF_SHL = 3;
    localparam int OFF_SHR = 4;
    localparam int OFF_LANE0 = 5;

    typedef enum logic [2:0] {
        WOP_NONE,
        WOP_LOAD,
        WOP_ADD,
        WOP_SUB,
        WOP_SHL,
        WOP_SHR,
        WOP_LANE
    } wr_op_e;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PLAIN,
        RK_INV,
        RK_NEG,
        RK_ZERO,
        RK_LANE
    } rd_kind_e;

    typedef struct packed {
        wr_op_e   wop;
        rd_kind_e rk;
    } acc_access_t;

    // Number of offsets the window spans for a given lane count.
    function automatic int window_span(input int lanes);
        return OFF_LANE0 + lanes;
    endfunction

endpackage

// File: rtl/acc_port_decode.sv
module acc_port_decode
    import acc_port_alu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h28,
    parameter int LANES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output acc_access_t       acc_op,
    output logic [LANES-1:0]  lane_sel
);
    localparam int SPAN = window_span(LANES);

    logic [ADDR_W-1:0] off;
    logic              in_win;

    assign off    = addr - BASE_ADDR;
    assign in_win = (addr >= BASE_ADDR) && (off < ADDR_W'(SPAN));

    // One select line per byte lane.
    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign lane_sel[gi] = in_win && (off == ADDR_W'(OFF_LANE0 + gi));
        end
    endgenerate

    wr_op_e   wop_raw;
    rd_kind_e rk_raw;

    always_comb begin
        wop_raw = WOP_NONE;
        rk_raw  = RK_NONE;
        if (in_win) begin
            if (off == ADDR_W'(OFF_PLAIN)) begin
                wop_raw = WOP_LOAD;
                rk_raw  = RK_PLAIN;
            end else if (off == ADDR_W'(OFF_ADDSUM)) begin
                wop_raw = WOP_ADD;
                rk_raw  = RK_INV;
            end else if (off == ADDR_W'(OFF_SUBNEG)) begin
                wop_raw = WOP_SUB;
                rk_raw  = RK_NEG;
            end else if (off == ADDR_W'(OFF_SHL)) begin
                wop_raw = WOP_SHL;
                rk_raw  = RK_ZERO;
            end else if (off == ADDR_W'(OFF_SHR)) begin
                wop_raw = WOP_SHR;
                rk_raw  = RK_ZERO;
            end else begin
                wop_raw = WOP_LANE;
                rk_raw  = RK_LANE;
            end
        end
    end

    always_comb begin
        acc_op.wop = wr_en ? wop_raw : WOP_NONE;
        acc_op.rk  = rd_en ? rk_raw  : RK_NONE;
    end

endmodule

// File: rtl/acc_update.sv
module acc_update
    import acc_port_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES = DATA_W / 8
) (
    input  wr_op_e            wop,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] acc_next
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   sh_amt;
    logic [DATA_W-1:0] lane_merged;

    assign sh_amt = wdata[SH_W-1:0];

    // Each byte lane takes the low byte of the write data when selected.
    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_merge
            assign lane_merged[gi*8 +: 8] = lane_sel[gi] ? wdata[7:0] : acc[gi*8 +: 8];
        end
    endgenerate

    always_comb begin
        unique case (wop)
            WOP_LOAD: acc_next = wdata;
            WOP_ADD:  acc_next = acc + wdata;
            WOP_SUB:  acc_next = acc - wdata;
            WOP_SHL:  acc_next = acc << sh_amt;
            WOP_SHR:  acc_next = acc >> sh_amt;
            WOP_LANE: acc_next = lane_merged;
            default:  acc_next = acc;
        endcase
    end

endmodule

// File: rtl/acc_read_mux.sv
module acc_read_mux
    import acc_port_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES = DATA_W / 8
) (
    input  rd_kind_e          rk,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] acc,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] lane_view;

    always_comb begin
        lane_view = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel[i]) begin
                lane_view = DATA_W'(acc[i*8 +: 8]);
            end
        end
    end

    always_comb begin
        unique case (rk)
            RK_PLAIN: rdata = acc;
            RK_INV:   rdata = ~acc;
            RK_NEG:   rdata = '0 - acc;
            RK_LANE:  rdata = lane_view;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/acc_port_alu.sv
module acc_port_alu
    import acc_port_alu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LANES = DATA_W / 8;

    acc_access_t       acc_op;
    logic [LANES-1:0]  lane_sel;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;

    acc_port_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .LANES    (LANES)
    ) u_decode (
        .addr    (port_addr),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .acc_op  (acc_op),
        .lane_sel(lane_sel)
    );

    acc_update #(
        .DATA_W(DATA_W),
        .LANES (LANES)
    ) u_update (
        .wop     (acc_op.wop),
        .lane_sel(lane_sel),
        .acc     (acc_q),
        .wdata   (wr_data),
        .acc_next(acc_d)
    );

    acc_read_mux #(
        .DATA_W(DATA_W),
        .LANES (LANES)
    ) u_rmux (
        .rk      (acc_op.rk),
        .lane_sel(lane_sel),
        .acc     (acc_q),
        .rdata   (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/acc_port_alu_chk.sv
module acc_port_alu_chk
    import acc_port_alu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h28
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] port_addr,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] acc
);
    localparam int SH_W = $clog2(DATA_W);
    localparam int SPAN = window_span(DATA_W / 8);
    localparam logic [ADDR_W-1:0] A_PLAIN = BASE_ADDR + ADDR_W'(OFF_PLAIN);
    localparam logic [ADDR_W-1:0] A_ADD   = BASE_ADDR + ADDR_W'(OFF_ADDSUM);
    localparam logic [ADDR_W-1:0] A_SUB   = BASE_ADDR + ADDR_W'(OFF_SUBNEG);
    localparam logic [ADDR_W-1:0] A_SHL   = BASE_ADDR + ADDR_W'(OFF_SHL);
    localparam logic [ADDR_W-1:0] A_SHR   = BASE_ADDR + ADDR_W'(OFF_SHR);
    localparam logic [ADDR_W-1:0] A_LANE0 = BASE_ADDR + ADDR_W'(OFF_LANE0);
    localparam logic [ADDR_W-1:0] A_LAST  = BASE_ADDR + ADDR_W'(SPAN - 1);

    logic outside;
    assign outside = (port_addr < BASE_ADDR) || (port_addr > A_LAST);

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> (acc == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == A_PLAIN) |=> (acc == $past(wr_data)));

    p_plain_rd_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_addr == A_PLAIN) |-> (rd_data == acc));

    p_add_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == A_ADD) |=> (acc == $past(acc) + $past(wr_data)));

    p_inv_rd_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_addr == A_ADD) |-> ((rd_data ^ acc) == '1));

    p_sub_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == A_SUB) |=> (acc == $past(acc) - $past(wr_data)));

    p_neg_rd_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_addr == A_SUB) |-> ((rd_data + acc) == '0));

    p_shl_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == A_SHL) |=> (acc == ($past(acc) << $past(wr_data[SH_W-1:0]))));

    p_shr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == A_SHR) |=> (acc == ($past(acc) >> $past(wr_data[SH_W-1:0]))));

    p_lane0_wr_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_addr == A_LANE0) |=>
            (acc[7:0] == $past(wr_data[7:0]) && acc[DATA_W-1:8] == $past(acc[DATA_W-1:8])));

    p_lane0_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_addr == A_LANE0) |-> (rd_data == DATA_W'(acc[7:0])));

    p_read_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> $stable(acc));

    p_wo_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (port_addr == A_SHL || port_addr == A_SHR)) |-> (rd_data == '0));

    p_outside_wr_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && outside) |=> $stable(acc));

    p_outside_rd_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && outside) |-> (rd_data == '0));

    p_idle_rd_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

endmodule

bind acc_port_alu acc_port_alu_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .port_addr(port_addr),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .acc      (acc_q)
);

// File: tb/tb_acc_port_alu.sv
module tb_acc_port_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  port_addr = 8'h00;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;

    int checks = 0;
    int failures = 0;
    logic [31:0] model;

    always #5 clk = ~clk;

    acc_port_alu dut (
        .clk      (clk),
        .rst      (rst),
        .port_addr(port_addr),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        port_addr = a;
        wr_data   = d;
        wr_en     = 1'b1;
        @(negedge clk);
        wr_en     = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        port_addr = a;
        rd_en     = 1'b1;
        #1;
        check(req, rd_data, exp);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        do_read(8'h28, 32'h0, "R1 reset value");
        #1;
        check("R11 idle read bus", rd_data, 32'h0);
    endtask

    task automatic t_load;
        do_write(8'h28, 32'hDEADBEEF);
        do_read(8'h28, 32'hDEADBEEF, "R2 load/read");
        do_read(8'h28, 32'hDEADBEEF, "R9 read keeps value");
    endtask

    task automatic t_add_sub;
        do_write(8'h28, 32'hFFFFFFFF);
        do_write(8'h29, 32'h00000002);
        do_read(8'h28, 32'h00000001, "R3 add wraps");
        do_write(8'h29, 32'h12340000);
        do_read(8'h28, 32'h12340001, "R3 add");
        do_read(8'h29, 32'hEDCBFFFE, "R3 inverted read");
        do_write(8'h28, 32'h0);
        do_write(8'h2A, 32'h1);
        do_read(8'h28, 32'hFFFFFFFF, "R4 sub wraps");
        do_write(8'h28, 32'h5);
        do_read(8'h2A, 32'hFFFFFFFB, "R4 negated read");
        do_read(8'h28, 32'h5, "R9 negated read keeps value");
        do_write(8'h28, 32'h0);
        do_read(8'h2A, 32'h0, "R4 negate zero");
    endtask

    task automatic t_shifts;
        do_write(8'h28, 32'h8000_0F01);
        do_write(8'h2B, 32'hFFFF_FFE4);
        do_read(8'h28, 32'h0000_F010, "R5 shl by 4, high bits ignored");
        do_write(8'h2B, 32'h0);
        do_read(8'h28, 32'h0000_F010, "R5 shl by 0");
        do_write(8'h28, 32'h1);
        do_write(8'h2B, 32'd31);
        do_read(8'h28, 32'h8000_0000, "R5 shl by 31");
        do_write(8'h2C, 32'd31);
        do_read(8'h28, 32'h1, "R6 shr by 31 zero fill");
        do_write(8'h28, 32'hF000_0000);
        do_write(8'h2C, 32'h0000_0028);
        do_read(8'h28, 32'h00F0_0000, "R6 shr by 8 logical");
        do_read(8'h2B, 32'h0, "R9 shl port reads zero");
        do_read(8'h2C, 32'h0, "R9 shr port reads zero");
    endtask

    task automatic t_lanes;
        model = 32'h1122_3344;
        do_write(8'h28, model);
        for (int k = 0; k < 4; k++) begin
            do_read(8'h2D + 8'(k), 32'(model[k*8 +: 8]), "R8 lane read");
        end
        for (int k = 0; k < 4; k++) begin
            do_write(8'h2D + 8'(k), 32'hABCD_EF00 | 32'(8'hA0 + 8'(k)));
            model[k*8 +: 8] = 8'hA0 + 8'(k);
            do_read(8'h28, model, "R7 lane write");
        end
        do_read(8'h30, 32'h0000_00A3, "R8 top lane zero-extended");
    endtask

    task automatic t_outside;
        do_write(8'h28, 32'h0BAD_F00D);
        do_write(8'h27, 32'h1);
        do_write(8'h31, 32'h2);
        do_write(8'hFF, 32'h3);
        do_read(8'h28, 32'h0BAD_F00D, "R10 outside writes ignored");
        do_read(8'h27, 32'h0, "R10 read below window");
        do_read(8'h31, 32'h0, "R10 read above window");
    endtask

    task automatic t_read_write_same;
        do_write(8'h28, 32'h10);
        @(negedge clk);
        port_addr = 8'h29;
        rd_en     = 1'b1;
        wr_en     = 1'b1;
        wr_data   = 32'h5;
        #1;
        check("R11 read sees pre-write value", rd_data, 32'hFFFF_FFEF);
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        do_read(8'h28, 32'h15, "R11 write applied at edge");
    endtask

    task automatic t_reset_again;
        do_write(8'h28, 32'h7777_7777);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_read(8'h28, 32'h0, "R1 reset clears");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_add_sub();
        t_shifts();
        t_lanes();
        t_outside();
        t_read_write_same();
        t_reset_again();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule